// File: doc/BRIEF.md
# Quadrature Sampling-Phase Clock Generator

This block derives the switch controls for a four-capacitor quadrature sampling detector from one reference clock. A two-bit state steps through four quarter-cycle phases. The block brings the state out as a 50% in-phase / quadrature square-wave pair. It also decodes the state into four phase enables, one for each quarter of the output cycle, each high for one quarter.

Two division schemes share the same state. In divide-by-4 mode, a reference at four times the output frequency advances both state bits on its rising edge, and the reference duty cycle does not matter. In divide-by-2 mode, a reference at twice the output frequency advances the leading bit on its rising edges and the lagging bit on its falling edges. This mode therefore depends on a 50% reference duty cycle, because any skew between the two edges shows up as quadrature phase error. Each output passes through its own XOR with a static polarity bit, so true and inverted outputs have the same logic depth. The block has no data stream; all pins are plain control and clock-derived levels.

Top module: `qsd_phase_gen`

## Requirements
- R1: While `srst` is high at a rising reference edge, the state is cleared to phase 0. With polarity all zero, this gives I=0, Q=0 and `ph_en_o`=4'b0001.
- R2: With `div2_mode`=0, the state advances one phase per rising edge. The phases run 0,1,2,3,0 and (I,Q) follows 00, 10, 11, 01, 00.
- R3: With `div2_mode`=1, the state advances one phase on every reference edge. I changes only at rising edges and Q only at falling edges, with the same (I,Q) order as R2. Over one full reference period, both I and Q invert.
- R4: Before polarity, exactly one enable is high at any time. `ph_en_o[k]` is high in phase k: k=0 when (I,Q)=00, k=1 when 10, k=2 when 11, and k=3 when 01.
- R5: Over any eight consecutive phase steps, each enable is high for exactly two steps, which is one quarter of the output period.
- R6: Q lags I by one phase step: the unpolarised Q after a step equals the unpolarised I before it.
- R7: `pol[0]` inverts I, `pol[1]` inverts Q, and `pol[2+k]` inverts `ph_en_o[k]`. A set bit inverts its output and does not shift any transition in time.
- R8: If `div2_mode` differs at a rising edge from its value at the previous rising edge, that edge forces the state to phase 0. Stepping then resumes in the new mode from phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock (4X output rate in divide-by-4 mode, 2X in divide-by-2 mode) |
| srst | input | 1 | Synchronous reset, active high, sampled on the rising edge |
| div2_mode | input | 1 | 0 selects divide-by-4, 1 selects dual-edge divide-by-2 |
| pol | input | 6 | Static polarity: bit 0 for I, bit 1 for Q, bits 5:2 for the phase enables 0..3 |
| i_o | output | 1 | In-phase 50% square wave |
| q_o | output | 1 | Quadrature 50% square wave, one quarter period behind I |
| ph_en_o | output | 4 | Quarter-cycle switch enables for phases 0, 90, 180, 270 degrees |

## Verification
Each mode is run after reset with all-clear, all-set and two mixed polarity words. Comparing the clear and set runs shows that inversion leaves every transition at the same step, and the mixed words catch a polarity bit routed to the wrong output. In divide-by-2 mode, sampling after each falling edge as well as each rising edge shows whether Q moves on the correct edge. Mode switches in both directions are made from a non-zero phase, so that a switch which skips or keeps the old state is visible. A reset asserted from phase 3 shows that the clear works while the state is running.

// File: rtl/qsd_phase_pkg.sv
`timescale 1ns/1ps
package qsd_phase_pkg;

  localparam int NUM_PH = 4;
  localparam int POL_W  = NUM_PH + 2;

  localparam logic MODE_DIV4 = 1'b0;
  localparam logic MODE_DIV2 = 1'b1;

  typedef struct packed {
    logic lag;
    logic lead;
  } qstate_t;

  // Phase k uses the reflected-binary code of k: bit 0 drives lead, bit 1 drives lag.
  function automatic qstate_t phase_code(input int k);
    int g;
    qstate_t c;
    g      = k ^ (k >> 1);
    c.lead = g[0];
    c.lag  = g[1];
    return c;
  endfunction

endpackage

// File: rtl/qsd_johnson_core.sv
`timescale 1ns/1ps
module qsd_johnson_core
  import qsd_phase_pkg::*;
(
  input  logic ref_clk,
  input  logic srst,
  input  logic div2_mode,
  output logic lead_o,
  output logic lag_o
);

  logic mode_q;
  logic lead_q;
  logic lag_rise_q;
  logic lag_fall_q;
  logic lag_sel;
  logic mode_flip;

  // The lagging bit is held by one of two flops chosen by the settled mode.
  assign lag_sel   = (mode_q == MODE_DIV2) ? lag_fall_q : lag_rise_q;
  assign mode_flip = (div2_mode != mode_q);

  always_ff @(posedge ref_clk) begin
    if (srst) begin
      lead_q     <= 1'b0;
      lag_rise_q <= 1'b0;
      mode_q     <= div2_mode;
    end else if (mode_flip) begin
      lead_q     <= 1'b0;
      lag_rise_q <= 1'b0;
      mode_q     <= div2_mode;
    end else begin
      lead_q     <= ~lag_sel;
      lag_rise_q <= (mode_q == MODE_DIV4) ? lead_q : 1'b0;
    end
  end

  // Falling-edge half of the dual-edge divider; parked at zero in divide-by-4.
  always_ff @(negedge ref_clk) begin
    if (srst || (mode_q == MODE_DIV4)) begin
      lag_fall_q <= 1'b0;
    end else begin
      lag_fall_q <= lead_q;
    end
  end

  assign lead_o = lead_q;
  assign lag_o  = lag_sel;

endmodule

// File: rtl/qsd_phase_decode.sv
`timescale 1ns/1ps
module qsd_phase_decode
  import qsd_phase_pkg::*;
#(
  parameter int PHASES = NUM_PH
) (
  input  logic              lead_i,
  input  logic              lag_i,
  output logic [PHASES-1:0] en_o
);

  for (genvar k = 0; k < PHASES; k++) begin : g_ph
    localparam qstate_t CODE = phase_code(k);
    assign en_o[k] = (lead_i == CODE.lead) && (lag_i == CODE.lag);
  end

endmodule

// File: rtl/qsd_pol_xor.sv
`timescale 1ns/1ps
module qsd_pol_xor #(
  parameter int W = 6
) (
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] inv_i,
  output logic [W-1:0] d_o
);

  // One XOR per line, whether inverted or not, so every output has equal depth.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign d_o[b] = d_i[b] ^ inv_i[b];
  end

endmodule

// File: rtl/qsd_phase_gen.sv
`timescale 1ns/1ps
module qsd_phase_gen
  import qsd_phase_pkg::*;
(
  input  logic              ref_clk,
  input  logic              srst,
  input  logic              div2_mode,
  input  logic [POL_W-1:0]  pol,
  output logic              i_o,
  output logic              q_o,
  output logic [NUM_PH-1:0] ph_en_o
);

  logic              lead;
  logic              lag;
  logic [NUM_PH-1:0] en_raw;
  logic [POL_W-1:0]  out_raw;
  logic [POL_W-1:0]  out_pol;

  qsd_johnson_core u_core (
    .ref_clk   (ref_clk),
    .srst      (srst),
    .div2_mode (div2_mode),
    .lead_o    (lead),
    .lag_o     (lag)
  );

  qsd_phase_decode #(.PHASES(NUM_PH)) u_dec (
    .lead_i (lead),
    .lag_i  (lag),
    .en_o   (en_raw)
  );

  assign out_raw = {en_raw, lag, lead};

  qsd_pol_xor #(.W(POL_W)) u_pol (
    .d_i   (out_raw),
    .inv_i (pol),
    .d_o   (out_pol)
  );

  assign i_o     = out_pol[0];
  assign q_o     = out_pol[1];
  assign ph_en_o = out_pol[POL_W-1:2];

endmodule

// File: rtl/qsd_phase_gen_chk.sv
`timescale 1ns/1ps
module qsd_phase_gen_chk
  import qsd_phase_pkg::*;
(
  input logic              ref_clk,
  input logic              srst,
  input logic              div2_mode,
  input logic [POL_W-1:0]  pol,
  input logic              i_o,
  input logic              q_o,
  input logic [NUM_PH-1:0] ph_en_o
);

  logic              i_raw;
  logic              q_raw;
  logic [NUM_PH-1:0] en_raw;

  assign i_raw  = i_o ^ pol[0];
  assign q_raw  = q_o ^ pol[1];
  assign en_raw = ph_en_o ^ pol[POL_W-1:2];

  p_onehot_rise_r4: assert property (@(posedge ref_clk) disable iff (srst)
    $onehot(en_raw));

  p_onehot_fall_r4: assert property (@(negedge ref_clk) disable iff (srst)
    $onehot(en_raw));

  // R2 and R6: one step per rising edge, Q takes the old I
  p_div4_step_r2: assert property (@(posedge ref_clk) disable iff (srst)
    (!$past(srst) && !$past(div2_mode) && !$past(div2_mode, 2))
      |-> (i_raw == !$past(q_raw)) && (q_raw == $past(i_raw)));

  // R3: two steps per reference period complement both bits
  p_div2_period_r3: assert property (@(posedge ref_clk) disable iff (srst)
    (!$past(srst) && $past(div2_mode) && $past(div2_mode, 2))
      |-> (i_raw == !$past(i_raw)) && (q_raw == !$past(q_raw)));

  p_mode_flush_r8: assert property (@(posedge ref_clk) disable iff (srst)
    (!$past(srst) && ($past(div2_mode) != $past(div2_mode, 2)))
      |-> (!i_raw && !q_raw));

endmodule

bind qsd_phase_gen qsd_phase_gen_chk u_chk (
  .ref_clk   (ref_clk),
  .srst      (srst),
  .div2_mode (div2_mode),
  .pol       (pol),
  .i_o       (i_o),
  .q_o       (q_o),
  .ph_en_o   (ph_en_o)
);

// File: tb/qsd_phase_gen_tb_top.sv
`timescale 1ns/1ps
module qsd_phase_gen_tb_top;

  logic       ref_clk = 1'b0;
  logic       srst = 1'b1;
  logic       div2_mode = 1'b0;
  logic [5:0] pol = 6'b0;
  logic       i_o;
  logic       q_o;
  logic [3:0] ph_en_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #2.5 ref_clk = ~ref_clk;

  qsd_phase_gen dut_i (
    .ref_clk   (ref_clk),
    .srst      (srst),
    .div2_mode (div2_mode),
    .pol       (pol),
    .i_o       (i_o),
    .q_o       (q_o),
    .ph_en_o   (ph_en_o)
  );

  // {mode, pol[5:0]}
  localparam logic [6:0] VEC [0:5] = '{
    7'b0_000000, 7'b1_000000, 7'b0_111111,
    7'b1_111111, 7'b0_100110, 7'b1_011001
  };

  function automatic logic [5:0] expect_out(input int k, input logic [5:0] p);
    logic [3:0] oh;
    logic       ei;
    logic       eq;
    oh = 4'b0001 << k;
    ei = (k == 1) || (k == 2);
    eq = (k >= 2);
    return {oh, eq, ei} ^ p;
  endfunction

  task automatic check_phase(input int k, input string req);
    logic [5:0] got;
    logic [5:0] exp;
    got = {ph_en_o, q_o, i_o};
    exp = expect_out(k, pol);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: {en,q,i} actual %b expected %b (phase %0d)", req, got, exp, k);
    end
  endtask

  // Wait for the next state-advancing edge and settle.
  task automatic step(input logic m);
    if (m) @(ref_clk);
    else   @(posedge ref_clk);
    #2;
  endtask

  task automatic do_reset(input logic m, input logic [5:0] p);
    srst = 1'b1;
    div2_mode = m;
    pol = p;
    repeat (2) @(posedge ref_clk);
    #1;
    srst = 1'b0;
    check_phase(0, "R1 reset state");
    if (m) begin
      @(negedge ref_clk);
      #2;
      check_phase(0, "R3 first falling edge holds phase 0");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    // Table-driven pass over both modes and several polarity words
    for (int v = 0; v < 6; v++) begin
      logic       m;
      logic [5:0] p;
      int         hits [4];
      logic       prev_i;
      string      tag;
      m = VEC[v][6];
      p = VEC[v][5:0];
      do_reset(m, p);
      for (int j = 0; j < 4; j++) hits[j] = 0;
      prev_i = i_o ^ p[0];
      tag = m ? "R3 R4" : "R2 R4";
      if (p != 6'b0) tag = {tag, " R7"};
      for (int s = 0; s < 8; s++) begin
        logic [3:0] en_r;
        step(m);
        check_phase((s + 1) % 4, tag);
        en_r = ph_en_o ^ p[5:2];
        for (int j = 0; j < 4; j++) hits[j] += int'(en_r[j]);
        n_checks++;
        if ((q_o ^ p[1]) !== prev_i) begin
          n_errors++;
          $display("FAIL R6 lag: q actual %b expected %b", q_o ^ p[1], prev_i);
        end
        prev_i = i_o ^ p[0];
      end
      for (int j = 0; j < 4; j++) begin
        n_checks++;
        if (hits[j] != 2) begin
          n_errors++;
          $display("FAIL R5 enable %0d on-steps actual %0d expected 2", j, hits[j]);
        end
      end
    end

    // R8: divide-by-4 to divide-by-2 from phase 2
    do_reset(1'b0, 6'b0);
    step(1'b0);
    step(1'b0);
    check_phase(2, "R8 pre-switch phase");
    div2_mode = 1'b1;
    @(posedge ref_clk); #2;
    check_phase(0, "R8 flush to phase 0 (to div2)");
    @(negedge ref_clk); #2;
    check_phase(0, "R8 div2 resumes from phase 0");
    @(posedge ref_clk); #2;
    check_phase(1, "R8 div2 first step");

    // R8: divide-by-2 to divide-by-4 from phase 2
    do_reset(1'b1, 6'b0);
    step(1'b1);
    check_phase(1, "R3 rising edge step");
    div2_mode = 1'b0;
    @(negedge ref_clk); #2;
    check_phase(2, "R3 falling edge step before switch");
    @(posedge ref_clk); #2;
    check_phase(0, "R8 flush to phase 0 (to div4)");
    @(posedge ref_clk); #2;
    check_phase(1, "R8 div4 first step");

    // R1: reset asserted mid-run from phase 3, with inverted polarity
    do_reset(1'b0, 6'b111111);
    step(1'b0); step(1'b0); step(1'b0);
    check_phase(3, "R2 phase 3 before reset");
    srst = 1'b1;
    @(posedge ref_clk); #2;
    check_phase(0, "R1 mid-run reset");
    @(posedge ref_clk); #2;
    check_phase(0, "R1 held in reset");
    srst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule